// File: doc/BRIEF.md
# Rotating-pointer interrupt status controller

This block gathers level interrupt requests from 32 or 64 internal sources and presents them to two CPU targets. It registers the raw source levels into a status vector. Each target has its own enable mask, so each target sees its own set of pending sources: the status bits that its mask allows. Software reaches the masked status, the masks and a per-target "next source" register through a simple register bus made of 32-bit words.

Each target has one interrupt line: the registered OR of its pending bits. To find out which source to service, software reads the target's next-source register. Hardware answers with the first pending source found by a circular search. The search starts at the target's own scan pointer. A successful read moves that pointer to just past the reported source, so no source is favoured over another and a busy source cannot starve the rest. The two targets keep separate pointers.

Register map, as a 4-bit word address: bit 3 selects the target (0 or 1), and bits 2:0 select the register. Offsets 0 and 1 hold the masked status words (read-only). Offsets 2 and 3 hold the mask words (read/write). Offset 4 is the next-source register. Offsets 5 to 7 are unused.

Top module: `rotscan_irq_ctrl`

## Requirements
- R1: A source is pending for a target only when its registered status bit and that target's mask bit are both 1. The masked status words read back exactly this pending vector.
- R2: With 64 sources, source n sits in word (n/32) XOR 1, at bit n[4:0]. Status offset 0 therefore holds sources 63..32 and offset 1 holds sources 31..0. Mask offsets 2 and 3 follow the same word order. With 32 sources only word 0 exists, at offsets 0 and 2.
- R3: After reset every mask bit is 0. Both interrupt outputs are low, and a next-source read returns 0.
- R4: `irq_out[t]` is high exactly when target t had at least one pending source in the previous cycle. A change on `src_in` reaches `irq_out` two clock edges later, because the status register and the output register each add one edge.
- R5: A next-source read returns bit 31 = 1 and bits [log2(sources)-1:0] = the index of the first pending source. The search runs upward from the target's pointer and wraps from the top source to 0. When nothing is pending, the read returns all zeros.
- R6: A next-source read that returns valid sets that target's pointer to (index+1) modulo the source count. An invalid read leaves the pointer unchanged, and so does any other access.
- R7: The two targets are independent. A mask write, a pointer move or a pending change for one target has no effect on the other target's reads or its interrupt output.
- R8: Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. The value reflects the state as it stood before that edge: a source level arriving in the same cycle as the read is not seen by it.
- R9: Reads at offsets 5 to 7 return 0. Writes there, and writes to status or next-source offsets, change no state. In the 32-source build the same holds for offsets 1 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NUM_SRC | Raw interrupt levels of the sources |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address: bit 3 selects the target, bits 2:0 the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 2 | Interrupt line of each target |

## Verification
Two things can happen in the same cycle: a next-source read, and a new source level being captured into the status register. The bench provokes this by raising a new source on the same clock edge that carries a next-source strobe. It checks that the reply is the source the search finds in the old status, and that the pointer then moves past that source. Only a second read may report anything influenced by the new arrival.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int WORD_W  = 32;
    localparam int NUM_TGT = 2;

    // register offsets inside one target's window
    localparam logic [2:0] OFF_STAT0 = 3'd0;
    localparam logic [2:0] OFF_STAT1 = 3'd1;
    localparam logic [2:0] OFF_MASK0 = 3'd2;
    localparam logic [2:0] OFF_MASK1 = 3'd3;
    localparam logic [2:0] OFF_NEXT  = 3'd4;
endpackage

// File: rtl/rsc_scan.sv
// Circular search: first set bit of pend at or above ptr, wrapping to 0.
module rsc_scan #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [2*N-1:0] dbl;
    logic [N-1:0]   rot;
    logic [IW-1:0]  ofs;

    always_comb begin
        // rot[j] = pend[(ptr + j) mod N]
        dbl   = {pend, pend} >> ptr;
        rot   = dbl[N-1:0];
        found = |rot;
        ofs   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (rot[i]) ofs = IW'(i);
        end
        idx = ptr + ofs;
    end
endmodule

// File: rtl/rsc_target.sv
// Per-target state: enable mask, scan pointer and registered interrupt line.
module rsc_target #(
    parameter int N     = 64,
    parameter int IW    = $clog2(N),
    parameter int WORDS = N / rsc_pkg::WORD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              status,
    input  logic                      wr_en,
    input  logic                      wr_chunk,
    input  logic [rsc_pkg::WORD_W-1:0] wr_data,
    input  logic                      scan_rd,
    output logic [N-1:0]              mask_o,
    output logic [N-1:0]              pend_o,
    output logic                      found_o,
    output logic [IW-1:0]             idx_o,
    output logic [IW-1:0]             ptr_o,
    output logic                      irq_o
);
    import rsc_pkg::*;

    typedef struct packed {
        logic [N-1:0]  mask;
        logic [IW-1:0] ptr;
        logic          irq;
    } tgt_st_t;

    tgt_st_t st_d, st_q;
    logic [N-1:0]  pend;
    logic          found;
    logic [IW-1:0] idx;

    assign pend = status & st_q.mask;

    rsc_scan #(.N(N), .IW(IW)) u_scan (
        .pend  (pend),
        .ptr   (st_q.ptr),
        .found (found),
        .idx   (idx)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int c = 0; c < WORDS; c++) begin
                if (WORDS == 1 || int'(wr_chunk) == c) begin
                    st_d.mask[c*WORD_W +: WORD_W] = wr_data;
                end
            end
        end
        if (scan_rd && found) begin
            st_d.ptr = idx + IW'(1);
        end
        st_d.irq = |pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o  = st_q.mask;
    assign pend_o  = pend;
    assign found_o = found;
    assign idx_o   = idx;
    assign ptr_o   = st_q.ptr;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/rotscan_irq_ctrl.sv
module rotscan_irq_ctrl #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [3:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [1:0]         irq_out
);
    import rsc_pkg::*;

    localparam int WORDS = NUM_SRC / WORD_W;
    localparam int IW    = $clog2(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [WORD_W-1:0]  rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic       tgt;
    logic [2:0] off;
    logic       word_ok;
    logic       chunk;
    logic       is_mask;

    logic [NUM_SRC-1:0] mask_a  [NUM_TGT];
    logic [NUM_SRC-1:0] pend_a  [NUM_TGT];
    logic [IW-1:0]      idx_a   [NUM_TGT];
    logic [IW-1:0]      ptr_a   [NUM_TGT];
    logic               found_a [NUM_TGT];

    // flat copies for the bound checker
    logic [NUM_SRC-1:0] pend_t0, pend_t1;
    logic [IW-1:0]      ptr_t0, ptr_t1;

    assign tgt     = bus_addr[3];
    assign off     = bus_addr[2:0];
    // word offset 1 exists only in the wide build
    assign word_ok = (WORDS == 2) || !off[0];
    // highest word at lowest offset
    assign chunk   = (WORDS == 2) ? ~off[0] : 1'b0;
    assign is_mask = (off == OFF_MASK0) || (off == OFF_MASK1);

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        logic sel;
        assign sel = (tgt == t[0]);

        rsc_target #(.N(NUM_SRC), .IW(IW), .WORDS(WORDS)) u_tgt (
            .clk      (clk),
            .rst_n    (rst_n),
            .status   (st_q.status),
            .wr_en    (bus_wr && sel && is_mask && word_ok),
            .wr_chunk (chunk),
            .wr_data  (bus_wdata),
            .scan_rd  (bus_rd && sel && (off == OFF_NEXT)),
            .mask_o   (mask_a[t]),
            .pend_o   (pend_a[t]),
            .found_o  (found_a[t]),
            .idx_o    (idx_a[t]),
            .ptr_o    (ptr_a[t]),
            .irq_o    (irq_out[t])
        );
    end

    assign pend_t0 = pend_a[0];
    assign pend_t1 = pend_a[1];
    assign ptr_t0  = ptr_a[0];
    assign ptr_t1  = ptr_a[1];

    always_comb begin
        logic [WORD_W-1:0] rsel;
        int                cidx;
        st_d        = st_q;
        st_d.status = src_in;
        cidx        = int'(chunk);
        rsel        = '0;
        unique case (off)
            OFF_STAT0, OFF_STAT1: begin
                if (word_ok) rsel = pend_a[tgt][cidx*WORD_W +: WORD_W];
            end
            OFF_MASK0, OFF_MASK1: begin
                if (word_ok) rsel = mask_a[tgt][cidx*WORD_W +: WORD_W];
            end
            OFF_NEXT: begin
                rsel[WORD_W-1] = found_a[tgt];
                if (found_a[tgt]) rsel[IW-1:0] = idx_a[tgt];
            end
            default: rsel = '0;
        endcase
        if (bus_rd) st_d.rdata = rsel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rd,
    input logic [3:0]    bus_addr,
    input logic [31:0]   bus_rdata,
    input logic [1:0]    irq_out,
    input logic [N-1:0]  pend0,
    input logic [N-1:0]  pend1,
    input logic [IW-1:0] ptr0,
    input logic [IW-1:0] ptr1
);
    logic          rd0_p, rd1_p;
    logic [N-1:0]  pend0_p, pend1_p;
    logic [IW-1:0] ptr0_p, ptr1_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd0_p   <= 1'b0;
            rd1_p   <= 1'b0;
            pend0_p <= '0;
            pend1_p <= '0;
            ptr0_p  <= '0;
            ptr1_p  <= '0;
        end else begin
            rd0_p   <= bus_rd && (bus_addr == 4'h4);
            rd1_p   <= bus_rd && (bus_addr == 4'hC);
            pend0_p <= pend0;
            pend1_p <= pend1;
            ptr0_p  <= ptr0;
            ptr1_p  <= ptr1;
        end
    end

    assert_valid_is_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_p && bus_rdata[31]) |-> pend0_p[bus_rdata[IW-1:0]]);

    assert_invalid_means_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_p && !bus_rdata[31]) |-> (pend0_p == '0 && bus_rdata == 32'h0));

    assert_ptr_follows_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_p && bus_rdata[31]) |-> (ptr0 == bus_rdata[IW-1:0] + IW'(1)));

    assert_ptr_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd0_p || !bus_rdata[31]) |-> (ptr0 == ptr0_p));

    assert_ptr1_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd1_p || !bus_rdata[31]) |-> (ptr1 == ptr1_p));

    assert_irq0_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[0] == (|pend0_p));

    assert_irq1_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[1] == (|pend1_p));
endmodule

bind rotscan_irq_ctrl rsc_chk #(.N(NUM_SRC), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .pend0     (pend_t0),
    .pend1     (pend_t1),
    .ptr0      (ptr_t0),
    .ptr1      (ptr_t1)
);

// File: tb/tb_rotscan_irq_ctrl.sv
`timescale 1ns/1ps
module tb_rotscan_irq_ctrl;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_in = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [1:0]    irq_out;

    int nchk  = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    rotscan_irq_ctrl #(.NUM_SRC(N)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic setsrc(input logic [N-1:0] v);
        @(negedge clk);
        src_in = v;
    endtask

    function automatic logic [N-1:0] bit_of(input int n);
        return {{(N-1){1'b0}}, 1'b1} << n;
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        chk("R3 irq after reset", {30'h0, irq_out}, 32'h0);
        rd(4'h4, d); chk("R3 next t0 after reset", d, 32'h0);
        rd(4'hC, d); chk("R3 next t1 after reset", d, 32'h0);
        rd(4'h2, d); chk("R3 mask word0 reset", d, 32'h0);
        rd(4'h3, d); chk("R3 mask word1 reset", d, 32'h0);
    endtask

    task automatic t_word_order;
        logic [31:0] d;
        wr(4'h2, 32'hFFFF_FFFF);
        wr(4'h3, 32'hFFFF_FFFF);
        setsrc(bit_of(5) | bit_of(40));
        rd(4'h0, d); chk("R2 status off0 holds 63..32", d, 32'h0000_0100);
        rd(4'h1, d); chk("R2 status off1 holds 31..0", d, 32'h0000_0020);
        wr(4'h2, 32'h0000_00F0);
        rd(4'h2, d); chk("R2 mask readback off2", d, 32'h0000_00F0);
        rd(4'h0, d); chk("R1 masked status drops src 40", d, 32'h0000_0000);
        rd(4'h1, d); chk("R1 masked status keeps src 5", d, 32'h0000_0020);
    endtask

    task automatic t_irq_timing;
        wr(4'h2, 32'h0000_0100);
        wr(4'h3, 32'h0);
        setsrc(bit_of(5));
        @(negedge clk); @(negedge clk);
        chk("R4 masked-off source no irq", {31'h0, irq_out[0]}, 32'h0);
        setsrc(bit_of(5) | bit_of(40));
        @(negedge clk);
        chk("R4 irq not yet after one edge", {31'h0, irq_out[0]}, 32'h0);
        @(negedge clk);
        chk("R4 irq after two edges", {31'h0, irq_out[0]}, 32'h1);
        chk("R7 other target irq low", {31'h0, irq_out[1]}, 32'h0);
    endtask

    task automatic t_scan;
        logic [31:0] d;
        wr(4'h2, 32'hFFFF_FFFF);
        wr(4'h3, 32'hFFFF_FFFF);
        setsrc(bit_of(3) | bit_of(10) | bit_of(60));
        rd(4'h4, d); chk("R5 first from ptr 0", d, 32'h8000_0003);
        rd(4'h4, d); chk("R6 resumes after 3", d, 32'h8000_000A);
        rd(4'h4, d); chk("R6 resumes after 10", d, 32'h8000_003C);
        rd(4'h4, d); chk("R5 wraps to 3", d, 32'h8000_0003);
        setsrc('0);
        rd(4'h4, d); chk("R5 nothing pending", d, 32'h0);
        setsrc(bit_of(3));
        rd(4'h4, d); chk("R5 wrap from ptr 4", d, 32'h8000_0003);
        setsrc(bit_of(3) | bit_of(4));
        rd(4'h4, d); chk("R6 invalid read kept ptr", d, 32'h8000_0004);
    endtask

    task automatic t_targets;
        logic [31:0] d;
        wr(4'hB, 32'h0000_0008);
        setsrc(bit_of(3) | bit_of(10));
        rd(4'hC, d); chk("R7 t1 own mask and ptr", d, 32'h8000_0003);
        rd(4'h4, d); chk("R7 t0 unaffected by t1", d, 32'h8000_000A);
        rd(4'h9, d); chk("R7 t1 status word", d, 32'h0000_0008);
        @(negedge clk);
        chk("R7 both irqs high", {30'h0, irq_out}, 32'h3);
    endtask

    task automatic t_same_cycle;
        logic [31:0] d;
        // t0 pointer is 11; new source 20 arrives on the read edge
        @(negedge clk);
        src_in = bit_of(3) | bit_of(10) | bit_of(20);
        bus_rd = 1'b1; bus_addr = 4'h4;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R8 read ignores same-cycle arrival", bus_rdata, 32'h8000_0003);
        rd(4'h4, d); chk("R8 next read after arrival", d, 32'h8000_000A);
        @(negedge clk);
        chk("R8 rdata holds without read", bus_rdata, 32'h8000_000A);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        rd(4'h5, d); chk("R9 offset 5 reads zero", d, 32'h0);
        rd(4'hF, d); chk("R9 offset 7 reads zero", d, 32'h0);
        wr(4'hE, 32'hFFFF_FFFF);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hA, d); chk("R9 t1 mask word0 untouched", d, 32'h0);
        rd(4'hB, d); chk("R9 t1 mask word1 untouched", d, 32'h0000_0008);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_order();
        t_irq_timing();
        t_scan();
        t_targets();
        t_same_cycle();
        t_unmapped();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule